// File: doc/BRIEF.md
# Ten-Bit Deserializer with Boundary Slip

This block turns a recovered serial bit stream into ten-bit parallel words, one line-code symbol per word. Accepted bits shift into a serial-in parallel-out register. When a word is complete, all ten bits are copied at once into a separate output register. A bit counter runs in the bit-clock domain. It marks each word boundary with a load strobe one clock wide, and it also drives a word clock with half duty cycle for the logic downstream.

Because ten is not a power of two, no halving demultiplexer tree is used. The counter simply counts ten accepted bits per word. An alignment controller outside the block can ask for a boundary slip. The counter then stretches one word to eleven bit times and drops the oldest bit of that word. Every output word after that is shifted by one bit position. Repeating the slip walks the boundary until a sync symbol lands whole in the output word.

Top module: `word_deserializer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `word_out` becomes 0, `word_valid` becomes 0, `word_clk` becomes 1 and the bit count returns to the start of a word. The first word after reset is made of the first ten accepted bits.
- R2: Bit order is MSB first. Of the ten bits in a word, the earliest accepted bit appears at `word_out[9]` and the latest at `word_out[0]`.
- R3: `word_out` changes only at the edge that accepts the last bit of a word, which is the tenth bit in a normal word. It holds its value at all other times.
- R4: `word_valid` is high for exactly one clock cycle. That is the cycle right after the edge at which `word_out` loads a new word.
- R5: A bit is accepted only at a rising edge where `bit_en` is high. Edges where `bit_en` is low change neither the bit count nor any output.
- R6: In a normal word, `word_clk` is high for the first 5 accepted bits and low for the last 5. It goes high in the same cycle as `word_valid`.
- R7: A `slip_req` seen high at any edge, with no slip pending, stretches the next word that completes to 11 accepted bits. The oldest of those 11 bits is dropped, and the extra bit time is added to the low phase of `word_clk` (6 bits low). If the request comes at the edge that ends a word, the following word is the one stretched.
- R8: While a slip is pending, further `slip_req` pulses are ignored. This includes the edge that completes the stretched word. Holding the request through a pending slip still gives an 11-bit word and not a 12-bit one.
- R9: On a stream that repeats one 10-bit pattern, at most 9 slips bring `word_out` to exactly that pattern, and it stays there with no further slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a clock edge that carries a valid serial bit |
| ser_in | input | 1 | Serial data bit |
| slip_req | input | 1 | Request to move the word boundary by one bit |
| word_out | output | 10 | Parallel word, earliest bit at the MSB |
| word_valid | output | 1 | One-cycle pulse when `word_out` updates |
| word_clk | output | 1 | Word-rate clock, high during the first half of each word |

## Verification
The hard cases are slip requests that arrive exactly at a word boundary, or while an earlier slip is still pending. A request only a cycle away from the counter's wrap decides which word gets stretched. So the stimulus sends slip pulses at random times while `bit_en` also drops out at random. It also holds a request high across a whole pending slip. Every cycle, a behavioural model that keeps its own bit queue and slip flag gives the expected outputs. A final phase closes the loop: it repeats one symbol pattern with a random phase offset and slips until the pattern is aligned.

// File: rtl/desr_pkg.sv
package desr_pkg;
  localparam int unsigned DEF_WORD_W = 10;

  function automatic int unsigned cnt_bits(input int unsigned word_w);
    return $clog2(word_w + 2);
  endfunction

  typedef enum logic [0:0] {
    WIDTH_NORMAL  = 1'b0,
    WIDTH_SLIPPED = 1'b1
  } word_width_e;
endpackage

// File: rtl/desr_shift_in.sv
module desr_shift_in #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              ser_in,
  output logic [WORD_W-1:0] shift_next
);
  logic [WORD_W-1:0] shift_q;

  assign shift_next = {shift_q[WORD_W-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (bit_en) begin
      shift_q <= shift_next;
    end
  end
endmodule

// File: rtl/desr_bit_counter.sv
module desr_bit_counter
  import desr_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic slip_req,
  output logic load_stb,
  output logic word_clk
);
  localparam int unsigned CW       = cnt_bits(WORD_W);
  localparam int unsigned HIGH_LEN = WORD_W / 2;
  localparam logic [CW-1:0] LAST_N = CW'(WORD_W - 1);
  localparam logic [CW-1:0] LAST_S = CW'(WORD_W);

  logic [CW-1:0] cnt_q, cnt_d, last_idx;
  word_width_e   width_q;
  logic          clk_q;

  assign last_idx = (width_q == WIDTH_SLIPPED) ? LAST_S : LAST_N;
  assign load_stb = bit_en && (cnt_q == last_idx);

  always_comb begin
    cnt_d = cnt_q;
    if (load_stb) begin
      cnt_d = '0;
    end else if (bit_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      width_q <= WIDTH_NORMAL;
      clk_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= (cnt_d < CW'(HIGH_LEN));
      if (width_q == WIDTH_SLIPPED) begin
        if (load_stb) begin
          width_q <= WIDTH_NORMAL;
        end
      end else if (slip_req) begin
        width_q <= WIDTH_SLIPPED;
      end
    end
  end

  assign word_clk = clk_q;
endmodule

// File: rtl/desr_word_reg.sv
module desr_word_reg #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_stb;
      if (load_stb) begin
        word_q <= word_in;
      end
    end
  end
endmodule

// File: rtl/word_deserializer.sv
module word_deserializer
  import desr_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              ser_in,
  input  logic              slip_req,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              word_clk
);
  logic [WORD_W-1:0] shift_next;
  logic              load_stb;

  desr_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in),
    .shift_next(shift_next)
  );

  desr_bit_counter #(.WORD_W(WORD_W)) u_count (
    .clk(clk), .rst(rst), .bit_en(bit_en), .slip_req(slip_req),
    .load_stb(load_stb), .word_clk(word_clk)
  );

  desr_word_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .load_stb(load_stb), .word_in(shift_next),
    .word_q(word_out), .valid_q(word_valid)
  );
endmodule

// File: rtl/word_deserializer_chk.sv
module word_deserializer_chk #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid,
  input logic              word_clk
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_out)); // R3
  AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> !word_valid); // R5
  AST_WCLK_RISE_AT_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(word_clk) |-> word_valid); // R6
  AST_VALID_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> word_clk); // R6
endmodule

bind word_deserializer word_deserializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .word_out(word_out),
  .word_valid(word_valid), .word_clk(word_clk)
);

// File: tb/word_deserializer_tb_top.sv
`timescale 1ns/1ps
module word_deserializer_tb_top;
  localparam int W = 10;
  localparam logic [W-1:0] PAT = 10'b0011111010;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, ser_in = 1'b0, slip_req = 1'b0;
  logic [W-1:0] word_out;
  logic word_valid, word_clk;
  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  word_deserializer #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in),
    .slip_req(slip_req), .word_out(word_out), .word_valid(word_valid),
    .word_clk(word_clk)
  );

  // behavioural reference
  bit q[$];
  bit m_armed;
  logic [W-1:0] m_word;
  bit m_valid, m_wclk;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_armed = 0; m_word = '0; m_valid = 0; m_wclk = 1;
    end else begin
      automatic int lim = m_armed ? W + 1 : W;
      automatic bit arm_new = slip_req && !m_armed;
      m_valid = 0;
      if (bit_en) begin
        q.push_back(ser_in);
        if (q.size() == lim) begin
          for (int k = 0; k < W; k++) m_word[W-1-k] = q[lim-W+k];
          m_valid = 1;
          q.delete();
          if (m_armed) m_armed = 0;
        end
      end
      if (arm_new) m_armed = 1;
      m_wclk = (q.size() < W / 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !rst) begin
    chk(word_out === m_word, "R3 word_out", word_out, m_word);
    chk(word_valid === m_valid, "R4 word_valid", word_valid, m_valid);
    chk(word_clk === m_wclk, "R6 R7 word_clk", word_clk, m_wclk);
  end

  task automatic drive(input bit e, input bit d, input bit s);
    @(negedge clk);
    bit_en = e; ser_in = d; slip_req = s;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int gap, slips, good;
    logic [W-1:0] v;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(word_out === '0 && word_valid === 1'b0 && word_clk === 1'b1, "R1 reset", {word_out, word_valid, word_clk}, 1);
    drive(0, 0, 0); rst = 0; cmp_on = 1;
    // R2 MSB-first known word
    v = 10'h2C5;
    for (int i = 0; i < W; i++) drive(1, v[W-1-i], 0);
    after_edge();
    chk(word_out === v && word_valid === 1'b1, "R2 msb first", word_out, v);
    // R5 idle edges
    drive(0, 1, 0);
    repeat (15) drive(0, 1, 0);
    after_edge();
    chk(word_valid === 1'b0 && word_out === v, "R5 idle hold", word_out, v);
    // random stream, full rate
    repeat (80) drive(1, 1'($urandom), 0);
    // random stream with gaps
    repeat (300) drive(1'($urandom % 3 != 0), 1'($urandom), 0);
    // random slips
    repeat (600) drive(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom % 17 == 0));
    // R7 / R8: hold slip for whole word at full rate, gap must be 11 not 12
    drive(1, 0, 0);
    do after_edge(); while (!word_valid);
    gap = 0;
    do begin
      drive(1, 1'($urandom), 1);
      after_edge(); gap++;
    end while (!word_valid);
    chk(gap == W + 1, "R7 R8 slipped length", gap, W + 1);
    drive(1, 0, 0);
    // R1 mid-word reset
    repeat (4) drive(1, 1, 0);
    rst = 1; drive(1, 1, 0); drive(0, 0, 0); rst = 0;
    gap = 0;
    do begin
      drive(1, 1'($urandom), 0);
      after_edge(); gap++;
    end while (!word_valid && gap < 30);
    chk(gap == W, "R1 restart count", gap, W);
    // R9 alignment search with random phase
    slips = 0; good = 0;
    for (int k = 0; k < 400 && good < 4; k++) begin
      automatic int idx = (k + 3) % W;
      automatic bit s = 0;
      drive(1, PAT[W-1-idx], 0);
      after_edge();
      if (word_valid) begin
        if (word_out != PAT) begin s = 1; slips++; good = 0; end
        else good++;
      end
      if (s) begin
        @(negedge clk); slip_req = 1;
        bit_en = 1; ser_in = PAT[W-1-((k + 4) % W)];
        k++;
        after_edge();
        @(negedge clk); slip_req = 0; bit_en = 0;
      end
    end
    chk(good >= 4, "R9 aligned", good, 4);
    chk(slips <= W - 1, "R9 slip count", slips, W - 1);
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    cmp_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule